// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block collects sixteen interrupt sources into one active-low request line for a processor. Each source arrives as a pulse and is caught on its rising edge. Every channel has four state bits: enable, pending, mask and in-service. Each of these is held as a low byte (channels 7..0) and a high byte (channels 15..8). Software reaches them through a small synchronous register port. The request line is asserted while any channel is pending, unmasked and not held off by an in-service bit.

When the processor runs an acknowledge cycle, the controller picks the highest-numbered eligible channel. It then drives a vector built from the upper nibble of its vector register and the 4-bit channel number, and it retires that channel's pending bit. Several controllers can share one acknowledge line through a priority chain. A device answers only while its chain input is low. It passes the chain on (output low) only when it has nothing to request and is not in the middle of answering. A mode bit selects between automatic and software end of interrupt. In software mode, acknowledging a channel sets its in-service bit, and that bit holds off this channel and every lower one until software clears it.

Top module: `intc_chain`

## Requirements
- R1: After reset, every register reads 0, `irq_n` is 1, `vec_oe` is 0, `vec_out` is 0, and `eo_n` equals `ei_n`.
- R2: A 0-to-1 transition on `src[i]` sets pending bit i at the next clock edge when enable bit i is 1. It has no effect when the enable bit is 0. A source held high sets nothing more after its pending bit is cleared.
- R3: A write to a pending byte clears every bit written as 0 and leaves every bit written as 1 unchanged. Writing an enable bit to 0 also clears that channel's pending bit.
- R4: `irq_n` is 0 exactly when some channel has pending=1, mask=1, and no in-service bit set at its own index or above. A mask bit of 0 holds its channel off without losing the pending bit.
- R5: An acknowledge starts on a clock edge where `iack_n`, `ds_n`, `ei_n` and `irq_n` are all 0 and no acknowledge is already open. From the next cycle, `vec_oe` is 1 and `vec_out` = {vector register bits 7:4, index of the highest eligible channel}, and that channel's pending bit is 0. Both outputs hold until `iack_n` or `ds_n` goes to 1. `vec_oe` then falls at the following edge, and `vec_out` reads 0 whenever `vec_oe` is 0.
- R6: While `ei_n` is 1, the acknowledge strobes produce no vector and leave the pending bits unchanged.
- R7: `eo_n` is 0 only while `ei_n` is 0, `irq_n` is 1 and no acknowledge is open.
- R8: With vector register bit 3 = 0 (automatic end of interrupt), an acknowledge sets no in-service bit.
- R9: With vector register bit 3 = 1 (software end of interrupt), an acknowledge sets the in-service bit of the served channel. Writing 0 to an in-service bit clears it, and writing 1 leaves it unchanged. Writing the vector register with bit 3 = 0 clears all in-service bits.
- R10: Register select codes are 0/1 enable low/high, 2/3 pending low/high, 4/5 mask low/high, 6/7 in-service low/high and 8 vector. Bit k of a low byte is channel k, and bit k of a high byte is channel k+8. The other codes read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src | input | 16 | Source request pulses, one per channel |
| reg_sel | input | 4 | Register select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| ds_n | input | 1 | Data strobe, active low |
| ei_n | input | 1 | Chain enable in, active low |
| eo_n | output | 1 | Chain enable out, active low |
| irq_n | output | 1 | Interrupt request, active low |
| vec_oe | output | 1 | Vector valid / drive enable |
| vec_out | output | 8 | Vector number |

## Verification
The main sweep raises every ordered pair of distinct channels in the same cycle, in both end-of-interrupt modes. A vector must name the higher channel first and the lower one on the next acknowledge. This tells a correct priority encoder apart from one that is inverted or off by one, and it catches a pending bit that is not retired. In software mode, the same pairs show the in-service hold-off: the lower channel must stay silent until its in-service bit is cleared. Single-channel patterns cover the remaining rules: a disabled source, a held-high source, a masked channel, write-one-has-no-effect on pending bits, a negated chain input, and the chain output with and without a request.

// File: rtl/intc_chain.sv
module intc_chain #(
  parameter int CH_W = 4,
  parameter int DW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<CH_W)-1:0]  src,
  input  logic [3:0]            reg_sel,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  output logic [DW-1:0]         rd_data,
  input  logic                  iack_n,
  input  logic                  ds_n,
  input  logic                  ei_n,
  output logic                  eo_n,
  output logic                  irq_n,
  output logic                  vec_oe,
  output logic [DW-1:0]         vec_out
);
  localparam int NCH = 1 << CH_W;
  localparam int HB  = NCH / 2;

  localparam logic [3:0] S_EN_L = 4'd0, S_EN_H = 4'd1, S_PD_L = 4'd2, S_PD_H = 4'd3,
                         S_MK_L = 4'd4, S_MK_H = 4'd5, S_SV_L = 4'd6, S_SV_H = 4'd7,
                         S_VEC  = 4'd8;

  logic [NCH-1:0] en, pend, mask, serv, src_q;
  logic [NCH-1:0] en_nx, pend_nx, serv_nx, blk, elig;
  logic [DW-1:0]  vreg, vec_q;
  logic [CH_W-1:0] win;
  logic           busy, ack_go, sw_mode;

  wire [NCH-1:0] rise = src & ~src_q;
  wire wr_lo = wr_en && (reg_sel[0] == 1'b0);
  wire wr_hi = wr_en && (reg_sel[0] == 1'b1);

  assign sw_mode = vreg[3];

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = NCH - 1; k >= 0; k--) begin
      acc    = acc | serv[k];
      blk[k] = acc;
    end
  end

  assign elig  = pend & mask & ~blk;
  assign irq_n = ~|elig;

  always_comb begin
    win = '0;
    for (int k = 0; k < NCH; k++)
      if (elig[k]) win = k[CH_W-1:0];
  end

  assign ack_go = !iack_n && !ds_n && !ei_n && !irq_n && !busy;
  assign eo_n   = ei_n | ~irq_n | busy;

  always_comb begin
    en_nx = en;
    if (wr_lo && reg_sel[3:1] == 3'd0) en_nx[HB-1:0]   = wr_data;
    if (wr_hi && reg_sel[3:1] == 3'd0) en_nx[NCH-1:HB] = wr_data;
  end

  always_comb begin
    pend_nx = pend;
    if (wr_lo && reg_sel[3:1] == 3'd1) pend_nx[HB-1:0]   = pend[HB-1:0] & wr_data;
    if (wr_hi && reg_sel[3:1] == 3'd1) pend_nx[NCH-1:HB] = pend[NCH-1:HB] & wr_data;
    if (ack_go) pend_nx[win] = 1'b0;
    pend_nx = (pend_nx | rise) & en_nx;
  end

  always_comb begin
    serv_nx = serv;
    if (wr_lo && reg_sel[3:1] == 3'd3) serv_nx[HB-1:0]   = serv[HB-1:0] & wr_data;
    if (wr_hi && reg_sel[3:1] == 3'd3) serv_nx[NCH-1:HB] = serv[NCH-1:HB] & wr_data;
    if (ack_go && sw_mode) serv_nx[win] = 1'b1;
    if (wr_en && reg_sel == S_VEC && !wr_data[3]) serv_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; pend <= '0; mask <= '0; serv <= '0; src_q <= '0;
      vreg <= '0; vec_q <= '0; busy <= 1'b0;
    end else begin
      src_q <= src;
      en    <= en_nx;
      pend  <= pend_nx;
      serv  <= serv_nx;
      if (wr_en && reg_sel == S_MK_L) mask[HB-1:0]   <= wr_data;
      if (wr_en && reg_sel == S_MK_H) mask[NCH-1:HB] <= wr_data;
      if (wr_en && reg_sel == S_VEC)  vreg <= wr_data;
      if (ack_go) begin
        busy  <= 1'b1;
        vec_q <= {vreg[DW-1:CH_W], win};
      end else if (iack_n || ds_n) begin
        busy <= 1'b0;
      end
    end
  end

  assign vec_oe  = busy;
  assign vec_out = busy ? vec_q : '0;

  always_comb begin
    case (reg_sel)
      S_EN_L:  rd_data = en[HB-1:0];
      S_EN_H:  rd_data = en[NCH-1:HB];
      S_PD_L:  rd_data = pend[HB-1:0];
      S_PD_H:  rd_data = pend[NCH-1:HB];
      S_MK_L:  rd_data = mask[HB-1:0];
      S_MK_H:  rd_data = mask[NCH-1:HB];
      S_SV_L:  rd_data = serv[HB-1:0];
      S_SV_H:  rd_data = serv[NCH-1:HB];
      S_VEC:   rd_data = vreg;
      default: rd_data = '0;
    endcase
  end

  p_pend_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en) == '0);

  p_vec_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe) |-> $past(!ei_n));

  p_eo_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> eo_n);

  p_sw_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_oe) && !$past(wr_en) && sw_mode) |-> serv[vec_out[CH_W-1:0]]);

  p_auto_no_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_oe) && !$past(wr_en) && !sw_mode) |-> !serv[vec_out[CH_W-1:0]]);

  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_out));
endmodule

// File: tb/intc_chain_test.sv
module intc_chain_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] src = '0;
  logic [3:0] reg_sel = '0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic iack_n = 1, ds_n = 1, ei_n = 0;
  logic eo_n, irq_n, vec_oe;
  logic [7:0] vec_out;
  int nchk = 0, nfail = 0, cyc = 0;

  intc_chain uut (.clk(clk), .rst_n(rst_n), .src(src), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .iack_n(iack_n), .ds_n(ds_n), .ei_n(ei_n),
    .eo_n(eo_n), .irq_n(irq_n), .vec_oe(vec_oe), .vec_out(vec_out));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(string r, int a, int e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic wr(int s, int d);
    reg_sel = s[3:0]; wr_data = d[7:0]; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int s, output int v);
    reg_sel = s[3:0]; #1; v = rd_data;
  endtask

  task automatic rd16(int lo, output int v);
    int a, b;
    rd(lo, a); rd(lo + 1, b); v = (b << 8) | a;
  endtask

  task automatic fire(int m);
    src = m[15:0];
    @(negedge clk);
    src = '0;
  endtask

  task automatic ack(output int v, output int oe);
    iack_n = 0; ds_n = 0;
    @(negedge clk);
    oe = vec_oe; v = vec_out;
    iack_n = 1; ds_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int v, oe;
    @(negedge clk); @(negedge clk);
    for (int s = 0; s < 16; s++) begin rd(s, v); chk("R1 reg", v, 0); end
    chk("R1 irq_n", irq_n, 1); chk("R1 vec_oe", vec_oe, 0); chk("R1 vec_out", vec_out, 0);
    chk("R1 eo_n", eo_n, 0);
    rst_n = 1;
    @(negedge clk);

    fire(16'h0010); rd(2, v); chk("R2 disabled", v, 0);
    wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    rd(4, v); chk("R10 mask lo", v, 8'hFF);
    wr(9, 8'h55); rd(9, v); chk("R10 unused", v, 0);

    src = 16'h0100; @(negedge clk);
    rd16(2, v); chk("R2 edge", v, 16'h0100);
    wr(3, 8'hFF); rd16(2, v); chk("R3 write one", v, 16'h0100);
    wr(3, 8'h00); @(negedge clk); rd16(2, v); chk("R2 held level", v, 0);
    src = '0; @(negedge clk);

    fire(16'h0002); wr(4, 8'h00);
    chk("R4 masked irq", irq_n, 1); rd(2, v); chk("R4 masked keeps pend", v, 2);
    chk("R7 eo no req", eo_n, 0);
    wr(4, 8'hFF); chk("R4 unmasked irq", irq_n, 0); chk("R7 eo with req", eo_n, 1);
    ei_n = 1; ack(v, oe); chk("R6 no vec", oe, 0); rd(2, v); chk("R6 pend kept", v, 2);
    chk("R7 eo ei high", eo_n, 1);
    ei_n = 0;
    wr(0, 8'hFD); rd(2, v); chk("R3 enable clears", v, 0); wr(0, 8'hFF);

    for (int m = 0; m < 2; m++) begin
      wr(8, 8'hA0 | (m << 3));
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++) begin
          fire((1 << i) | (1 << j));
          chk("R4 req", irq_n, 0);
          ack(v, oe);
          chk("R5 oe", oe, 1); chk("R5 first vec", v, 8'hA0 | j);
          chk("R5 oe drops", vec_oe, 0);
          rd16(6, v);
          if (m == 1) begin
            chk("R9 serv set", v, 1 << j); chk("R9 held off", irq_n, 1);
            wr(6, 8'h00); wr(7, 8'h00); rd16(6, v); chk("R9 serv cleared", v, 0);
          end else chk("R8 no serv", v, 0);
          chk("R4 lower req", irq_n, 0);
          ack(v, oe);
          chk("R5 second vec", v, 8'hA0 | i);
          if (m == 1) begin wr(6, 8'h00); wr(7, 8'h00); end
          rd16(2, v); chk("R5 pend retired", v, 0); chk("R5 irq idle", irq_n, 1);
        end
    end

    wr(8, 8'h38); fire(16'h0008); ack(v, oe); chk("R5 base", v, 8'h33);
    rd(6, v); chk("R9 serv", v, 8'h08);
    wr(6, 8'hFF); rd(6, v); chk("R9 write one", v, 8'h08);
    wr(8, 8'h30); rd(6, v); chk("R9 mode clear", v, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule